// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two integers over several clock cycles. It examines one multiplier bit per cycle and keeps a running partial sum. That sum rotates right together with the register that holds the multiplier, so each product bit pushed out of the sum takes the place of a multiplier bit that has already been used. When the loop ends, the sum register holds the upper half of the double-width product and the multiplier register holds the lower half.

Each operation chooses one of two operand sizes: a half-width byte form or a full-width word form. It also chooses unsigned or two's-complement arithmetic. For a signed operation, every negative operand is first replaced by its magnitude, and a sign flag toggles once for each such operand. If that flag is still set after the loop, the double-width result is negated one half at a time. The block then evaluates a carry flag and an overflow flag, which always take the same value.

The caller pulses `start` together with the operands and the mode bits. The block answers with a one-cycle `done` pulse, and the result stays on the outputs until the next operation is accepted.

Top module: `seq_mult`

## Requirements
- R1: After reset, `busy`, `done`, `cf` and `of` are 0, and `prod_hi` and `prod_lo` are both zero.
- R2: In word mode (`size_word`=1) with `is_signed`=0, {`prod_hi`,`prod_lo`} equals the full unsigned 2W-bit product of `opa` and `opb`. For example, 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R3: In byte mode (`size_word`=0), only bits [W/2-1:0] of each operand are used. The W-bit product is returned with its upper byte in `prod_hi`[W/2-1:0] and its lower byte in `prod_lo`[W/2-1:0]. Bits [W-1:W/2] of both outputs are zero.
- R4: With `is_signed`=1, the result is the two's-complement product of the sign-extended operands, at the selected size.
- R5: For an unsigned operation, `cf` and `of` are both 1 when the upper half of the product is nonzero, and both 0 otherwise.
- R6: For a signed operation, `cf` and `of` are both 1 when the upper half is not the sign extension of the top bit of the lower half, and both 0 otherwise.
- R7: `done` rises exactly N+3 clock edges after the edge that accepts `start`, where N is 16 for word mode and 8 for byte mode (W=16). `busy` is high from the accepting edge until `done` rises.
- R8: `done` is high for exactly one cycle. `prod_hi`, `prod_lo`, `cf` and `of` then hold their values until a new `start` is accepted.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the result nor the latency of the operation already running.
- R10: When both signed operands are negative, the product is positive. This includes the case of the most negative value times itself, for example 0x8000 times 0x8000 gives 0x40000000 with both flags set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation; accepted only while idle |
| size_word | input | 1 | 1 selects the full-width operands, 0 selects the half-width operands |
| is_signed | input | 1 | 1 selects two's-complement arithmetic |
| opa | input | W | First operand, the one held in the accumulator |
| opb | input | W | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| prod_hi | output | W | Upper half of the product |
| prod_lo | output | W | Lower half of the product |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag, always equal to cf |

## Verification
The operand patterns are chosen to separate failure modes that a simple product check would mix together.
- All-ones times all-ones, unsigned, exposes a lost carry-out in the running sum.
- Zero times a value, and one times a value, separate the flag-clear paths from the flag-set paths.
- Negative times positive, with a lower half that is zero after negation, tells the two's-complement upper-half path apart from the one's-complement path.
- Two negative operands, and the most negative value squared, show whether the sign flag toggles or is merely set.
- Byte operands with junk in their upper bits show whether the upper bits leak into the result.
- Signed results that land just inside and just outside the half-width range separate the signed flag rule from the unsigned one.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOOP  = 3'd2,
    ST_NEG   = 3'd3,
    ST_FLAGS = 3'd4
  } mul_state_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic size_word,
  output logic accept,
  output logic do_setup,
  output logic do_iter,
  output logic do_neg,
  output logic do_flags,
  output logic busy,
  output logic done
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned CW = $clog2(W);

  mul_state_t      state_q;
  logic [CW-1:0]   cnt_q;
  logic            word_q;

  assign accept   = start && (state_q == ST_IDLE);
  assign do_setup = (state_q == ST_SETUP);
  assign do_iter  = (state_q == ST_LOOP);
  assign do_neg   = (state_q == ST_NEG);
  assign do_flags = (state_q == ST_FLAGS);
  assign busy     = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      word_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          word_q  <= size_word;
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          cnt_q   <= word_q ? CW'(W - 1) : CW'(H - 1);
          state_q <= ST_LOOP;
        end
        ST_LOOP: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else             state_q <= ST_NEG;
        end
        ST_NEG:   state_q <= ST_FLAGS;
        ST_FLAGS: begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         do_setup,
  input  logic         do_iter,
  input  logic         do_neg,
  input  logic         do_flags,
  input  logic         size_word,
  input  logic         is_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum_q,
  output logic [W-1:0] mplr_q,
  output logic         cf,
  output logic         of,
  output logic         sgn_mode_q,
  output logic         word_mode_q,
  output logic         neg_flag_q
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] mcand_q;
  logic         cy_q;

  function automatic logic [W-1:0] size_mask(input logic word);
    return word ? {W{1'b1}} : {{(W-H){1'b0}}, {H{1'b1}}};
  endfunction

  function automatic logic top_bit(input logic [W-1:0] v, input logic word);
    return word ? v[W-1] : v[H-1];
  endfunction

  function automatic logic [W-1:0] negate2(input logic [W-1:0] v, input logic word);
    return (~v + 1'b1) & size_mask(word);
  endfunction

  // rotate right by one within the active width, feeding `in_bit` at the top
  function automatic logic [W-1:0] rot_in(input logic [W-1:0] v, input logic in_bit,
                                          input logic word);
    logic [W-1:0] r;
    r = v >> 1;
    if (word) r[W-1] = in_bit;
    else      r[H-1] = in_bit;
    return r & size_mask(word);
  endfunction

  logic [W-1:0] mask_now, mask_q, a_in, b_in;
  logic         a_neg, b_neg;
  logic [W:0]   add_full;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] hi_plus;
  logic         flag_val;

  assign mask_now = size_mask(size_word);
  assign mask_q   = size_mask(word_mode_q);
  assign a_in     = opa & mask_now;
  assign b_in     = opb & mask_now;
  assign a_neg    = is_signed && top_bit(a_in, size_word);
  assign b_neg    = is_signed && top_bit(b_in, size_word);

  assign add_full = {1'b0, sum_q} + {1'b0, (cy_q ? mcand_q : {W{1'b0}})};
  assign add_sum  = add_full[W-1:0] & mask_q;
  assign add_cout = word_mode_q ? add_full[W] : add_full[H];

  assign hi_plus  = (sum_q + {{(W-1){1'b0}}, top_bit(mplr_q, word_mode_q)}) & mask_q;
  assign flag_val = sgn_mode_q ? (hi_plus != '0) : (sum_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q       <= '0;
      mplr_q      <= '0;
      mcand_q     <= '0;
      cy_q        <= 1'b0;
      cf          <= 1'b0;
      of          <= 1'b0;
      sgn_mode_q  <= 1'b0;
      word_mode_q <= 1'b0;
      neg_flag_q  <= 1'b0;
    end else begin
      if (accept) begin
        mcand_q     <= a_neg ? negate2(a_in, size_word) : a_in;
        mplr_q      <= b_neg ? negate2(b_in, size_word) : b_in;
        neg_flag_q  <= a_neg ^ b_neg;
        sum_q       <= '0;
        cy_q        <= 1'b0;
        cf          <= 1'b0;
        of          <= 1'b0;
        sgn_mode_q  <= is_signed;
        word_mode_q <= size_word;
      end
      if (do_setup) begin
        cy_q   <= mplr_q[0];
        mplr_q <= rot_in(mplr_q, cy_q, word_mode_q);
      end
      if (do_iter) begin
        cy_q   <= mplr_q[0];
        mplr_q <= rot_in(mplr_q, add_sum[0], word_mode_q);
        sum_q  <= rot_in(add_sum, add_cout, word_mode_q);
      end
      if (do_neg && neg_flag_q) begin
        mplr_q <= negate2(mplr_q, word_mode_q);
        sum_q  <= (mplr_q == '0) ? negate2(sum_q, word_mode_q) : (~sum_q & mask_q);
      end
      if (do_flags) begin
        cf <= flag_val;
        of <= flag_val;
      end
    end
  end
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         size_word,
  input  logic         is_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic         cf,
  output logic         of
);
  logic accept_w, setup_w, iter_w, neg_w, flags_w;
  logic sgn_mode_w, word_mode_w, neg_flag_w;
  logic [W-1:0] sum_w, mplr_w;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .size_word(size_word),
    .accept(accept_w), .do_setup(setup_w), .do_iter(iter_w),
    .do_neg(neg_w), .do_flags(flags_w), .busy(busy), .done(done)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .do_setup(setup_w),
    .do_iter(iter_w), .do_neg(neg_w), .do_flags(flags_w),
    .size_word(size_word), .is_signed(is_signed), .opa(opa), .opb(opb),
    .sum_q(sum_w), .mplr_q(mplr_w), .cf(cf), .of(of),
    .sgn_mode_q(sgn_mode_w), .word_mode_q(word_mode_w), .neg_flag_q(neg_flag_w)
  );

  assign prod_hi = sum_w;
  assign prod_lo = mplr_w;
endmodule

// File: rtl/seq_mult_checker.sv
module seq_mult_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         cf,
  input logic         of,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo,
  input logic         sgn_mode,
  input logic         word_mode
);
  localparam int unsigned H = W / 2;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo) && $stable(cf)));

  p_run_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_rose_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_flag_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cf == of));

  p_unsigned_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sgn_mode) |-> (cf == (prod_hi != '0)));

  p_signed_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sgn_mode && word_mode) |-> (cf == (prod_hi != {W{prod_lo[W-1]}})));

  p_byte_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !word_mode) |-> ((prod_hi[W-1:H] == '0) && (prod_lo[W-1:H] == '0)));
endmodule

bind seq_mult seq_mult_checker #(.W(W)) u_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cf(cf), .of(of), .prod_hi(prod_hi), .prod_lo(prod_lo),
  .sgn_mode(sgn_mode_w), .word_mode(word_mode_w)
);

// File: tb/seq_mult_test.sv
module seq_mult_test;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, size_word = 1'b0, is_signed = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic busy, done, cf, of;
  logic [W-1:0] prod_hi, prod_lo;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_mult #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_word(size_word),
    .is_signed(is_signed), .opa(opa), .opb(opb), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo), .cf(cf), .of(of)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Reference product built from the requirements in wide integer arithmetic.
  task automatic expect_of(input logic [W-1:0] a, input logic [W-1:0] b,
                           input bit word, input bit sgn,
                           output logic [W-1:0] ehi, output logic [W-1:0] elo,
                           output bit eflag);
    int n;
    longint sa, sb, p;
    longint lo_part, hi_part, lim;
    n = word ? 16 : 8;
    if (word) begin
      sa = sgn ? longint'($signed(a)) : longint'(a);
      sb = sgn ? longint'($signed(b)) : longint'(b);
    end else begin
      sa = sgn ? longint'($signed(a[7:0])) : longint'(a[7:0]);
      sb = sgn ? longint'($signed(b[7:0])) : longint'(b[7:0]);
    end
    p = sa * sb;
    lo_part = p & ((64'sd1 <<< n) - 1);
    hi_part = (p >>> n) & ((64'sd1 <<< n) - 1);
    elo = W'(lo_part);
    ehi = W'(hi_part);
    lim = 64'sd1 <<< (n - 1);
    if (sgn) eflag = (p >= lim) || (p < -lim);
    else     eflag = (hi_part != 0);
  endtask

  // Launch one operation, optionally poke start while busy, measure latency.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit word, input bit sgn, input string req,
                        input bit poke_busy);
    logic [W-1:0] ehi, elo;
    bit eflag;
    int lat;
    int explat;
    expect_of(a, b, word, sgn, ehi, elo, eflag);
    explat = (word ? 16 : 8) + 3;
    @(negedge clk);
    opa = a; opb = b; size_word = word; is_signed = sgn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after accept", longint'(busy), 1);
    lat = 0;
    while (lat < 40) begin
      if (poke_busy && lat == 2) begin
        opa = ~a; opb = a ^ b; size_word = ~word; is_signed = ~sgn; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
      if (done) break;
    end
    start = 1'b0;
    check(lat == explat, poke_busy ? "R9" : "R7", "latency", lat, explat);
    check(prod_hi == ehi, req, "prod_hi", longint'(prod_hi), longint'(ehi));
    check(prod_lo == elo, req, "prod_lo", longint'(prod_lo), longint'(elo));
    check(cf == eflag && of == eflag, sgn ? "R6" : "R5", "cf/of",
          longint'({cf, of}), longint'({eflag, eflag}));
    @(negedge clk);
    check(done == 1'b0, "R8", "done pulse width", longint'(done), 0);
    check(prod_hi == ehi && prod_lo == elo, "R8", "result hold",
          longint'({prod_hi, prod_lo}), longint'({ehi, elo}));
  endtask

  task automatic t_reset;
    check(!busy && !done && !cf && !of, "R1", "control/flags after reset",
          longint'({busy, done, cf, of}), 0);
    check(prod_hi == '0 && prod_lo == '0, "R1", "product after reset",
          longint'({prod_hi, prod_lo}), 0);
  endtask

  task automatic t_unsigned_word;
    run_op(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R2", 1'b0);
    check({prod_hi, prod_lo} == 32'hFFFE0001, "R2", "ffff*ffff",
          longint'({prod_hi, prod_lo}), 64'hFFFE0001);
    run_op(16'h1234, 16'h0000, 1'b1, 1'b0, "R2", 1'b0);
    run_op(16'h00FF, 16'h0101, 1'b1, 1'b0, "R5", 1'b0);
    run_op(16'h0100, 16'h0100, 1'b1, 1'b0, "R5", 1'b0);
  endtask

  task automatic t_byte;
    run_op(16'hA5FF, 16'h3CFF, 1'b0, 1'b0, "R3", 1'b0);
    run_op(16'hFF0F, 16'h0010, 1'b0, 1'b0, "R3", 1'b0);
    run_op(16'h7780, 16'h1102, 1'b0, 1'b1, "R3", 1'b0);
  endtask

  task automatic t_signed;
    run_op(16'hFFFF, 16'h0003, 1'b1, 1'b1, "R4", 1'b0);
    run_op(16'hFF00, 16'h0100, 1'b1, 1'b1, "R4", 1'b0);
    run_op(16'h4000, 16'hFFFE, 1'b1, 1'b1, "R6", 1'b0);
    run_op(16'h4000, 16'h0002, 1'b1, 1'b1, "R6", 1'b0);
    run_op(16'h00F0, 16'h0008, 1'b0, 1'b1, "R6", 1'b0);
  endtask

  task automatic t_both_negative;
    run_op(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R10", 1'b0);
    run_op(16'h8000, 16'h8000, 1'b1, 1'b1, "R10", 1'b0);
    check({prod_hi, prod_lo} == 32'h40000000 && cf, "R10", "min*min",
          longint'({cf, prod_hi, prod_lo}), 64'h140000000);
    run_op(16'h0080, 16'h00FD, 1'b0, 1'b1, "R10", 1'b0);
  endtask

  task automatic t_busy_ignore;
    run_op(16'h1357, 16'h2468, 1'b1, 1'b0, "R9", 1'b1);
    run_op(16'h00C3, 16'h0091, 1'b0, 1'b1, "R9", 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned_word();
    t_byte();
    t_signed();
    t_both_negative();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule